// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block sits in front of a timer's counter and decides, on every cycle of the timer clock, whether the counter may advance. It produces a one-cycle count strobe. The strobe can come from three places. The first is the timer clock itself, which fires every cycle. The second is an external capture-channel pin. The third is a dedicated external trigger pin. Both pins are asynchronous to the timer clock. Each pin passes through a two-flop resynchronizer, then a polarity inversion, then a programmable digital glitch filter, and finally a rising-edge detector. On the trigger path, the qualified edges are also divided by 1, 2, 4 or 8 before they reach the strobe.

Software sets the source with a 3-bit slave-mode field, a 3-bit input-select field and a separate trigger-path enable. A software count enable gates every source, and the gating takes effect one cycle late. When the channel path is selected, a separate flag pulses on every qualified channel edge. Other logic can use this flag as a trigger indication.

Top module: `tclk_src_sel`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, `cnt_strobe` and `trig_flag` are 0.
- R2: With `ext2_en`=0 and `slave_mode`=3'b000, `cnt_strobe` is 1 in every cycle that follows a clock edge at which `cen` was 1, and 0 in the cycle after `cen` was sampled 0.
- R3: With `ext2_en`=0, `slave_mode`=3'b111, `trig_sel`=3'b110, `ch_pol`=0 and `ch_flt`=0, every rising edge of `ch_pin` gives exactly one one-cycle strobe. The strobe is observed in the cycle that follows the third clock edge after the pin change, so the pin-to-strobe latency is 3 cycles.
- R4: With `ch_pol`=1, falling edges of `ch_pin` are counted instead of rising ones. The same latency as R3 applies.
- R5: A filter code N greater than 0 accepts a change of the resynchronized level only after N consecutive samples differ from the accepted level. Shorter pulses are ignored, and an accepted edge strobes 3+N cycles after the pin change. This holds for both `ch_flt` and `trg_flt`.
- R6: In channel mode, any `trig_sel` value other than 3'b110 yields no strobe and no flag.
- R7: With `ext2_en`=1, qualified edges of `trg_pin` drive the strobe. These edges use their own polarity `trg_pol` (0 = rising) and their own filter `trg_flt`. With the prescaler at 1, the latency is 3+N cycles.
- R8: `trg_psc` codes 2'b00, 2'b01, 2'b10 and 2'b11 make one strobe per 1, 2, 4 and 8 qualified trigger edges. The first strobe after the trigger path is enabled comes on the last edge of the first group. The edge count is held clear while `ext2_en`=0.
- R9: `ext2_en`=1 overrides `slave_mode`. Neither the timer clock nor channel edges produce a strobe.
- R10: `trig_flag` pulses for one cycle on each qualified channel edge while `slave_mode`=3'b111 and `trig_sel`=3'b110. It does this regardless of `cen` and `ext2_en`, and in the same cycle the strobe would appear.
- R11: With `cen`=0, no source produces a strobe.
- R12: With `ext2_en`=0 and any `slave_mode` other than 3'b000 and 3'b111, no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cen | input | 1 | Software count enable |
| slave_mode | input | 3 | 000 = timer clock, 111 = channel-edge clocking, others = none |
| trig_sel | input | 3 | Channel input select for channel-edge clocking (110 = channel pin) |
| ext2_en | input | 1 | Enables trigger-pin clocking (overrides slave_mode) |
| ch_pin | input | 1 | Asynchronous channel pin |
| ch_pol | input | 1 | Channel polarity, 0 = rising, 1 = falling |
| ch_flt | input | 4 | Channel filter length in cycles, 0 = off |
| trg_pin | input | 1 | Asynchronous trigger pin |
| trg_pol | input | 1 | Trigger polarity, 0 = rising, 1 = falling |
| trg_flt | input | 4 | Trigger filter length in cycles, 0 = off |
| trg_psc | input | 2 | Trigger edge divider code, ratio 2^code |
| cnt_strobe | output | 1 | One-cycle count enable for the counter |
| trig_flag | output | 1 | One-cycle pulse on each qualified channel edge |

## Verification
The hardest situations to reach are those where the configuration changes while a pin is part-way through its pipeline. Examples are a polarity flip that creates an edge out of a steady pin, a filter code shortened while a run of samples is already under way, and a prescale code changed with edges already counted. Directed phases measure the exact latencies and the glitch rejection in isolation. After them, a long random phase drives both pins with short and long pulses and reloads the whole configuration every few dozen cycles. This lands such changes inside the resynchronizer and filter windows. A cycle-level model in the bench, built from sample queues and counters, predicts both outputs through all of it.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    // Field widths
    localparam int SEL_W     = 3;
    localparam int FLT_W     = 4;
    localparam int PSC_W     = 2;
    localparam int PSC_CNT_W = (1 << PSC_W) - 1;   // bits to count to 2^(2^PSC_W-1)-1
    localparam int N_PATHS   = 2;

    // Path indices
    localparam int PATH_CH  = 0;
    localparam int PATH_TRG = 1;

    // Encodings
    localparam logic [SEL_W-1:0] SMODE_INT  = 3'b000;
    localparam logic [SEL_W-1:0] SMODE_EXT1 = 3'b111;
    localparam logic [SEL_W-1:0] TSEL_CH    = 3'b110;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_INT  = 2'd1,
        SRC_CH   = 2'd2,
        SRC_TRG  = 2'd3
    } src_e;

    typedef struct packed {
        logic             pol;
        logic [FLT_W-1:0] flt;
    } cond_cfg_t;

    // Trigger path wins over the slave-mode field.
    function automatic src_e pick_src(input logic ext2, input logic [SEL_W-1:0] mode);
        if (ext2)                    return SRC_TRG;
        else if (mode == SMODE_EXT1) return SRC_CH;
        else if (mode == SMODE_INT)  return SRC_INT;
        else                         return SRC_NONE;
    endfunction

    // Terminal count of the edge divider: 2^code - 1
    function automatic logic [PSC_CNT_W-1:0] psc_limit(input logic [PSC_W-1:0] code);
        logic [PSC_CNT_W:0] one;
        one = {{PSC_CNT_W{1'b0}}, 1'b1};
        return PSC_CNT_W'((one << code) - 1'b1);
    endfunction

endpackage

// File: rtl/tclk_cond.sv
// Resynchronizer, polarity, digital filter and rising-edge detector for one pin.
module tclk_cond
    import tclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  cond_cfg_t cfg,
    output logic      edge_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic                   flt_q;
    logic [FLT_W-1:0]       run_q;
    logic                   filt_cur;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign lvl = sync_q[LAST] ^ cfg.pol;

    // A change is accepted after cfg.flt consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= 1'b0;
            run_q <= '0;
        end else if (cfg.flt == '0) begin
            flt_q <= lvl;
            run_q <= '0;
        end else if (lvl != flt_q) begin
            if (run_q >= cfg.flt - 1'b1) begin
                flt_q <= lvl;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign filt_cur = (cfg.flt == '0) ? lvl : flt_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= filt_cur;
    end

    assign edge_o = filt_cur & ~prev_q;

    // R3
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

    // R5
    filter_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_q != $past(flt_q)) |-> ($past(lvl) == flt_q));

endmodule

// File: rtl/tclk_div.sv
// Divides qualified edges by 2^code.
module tclk_div
    import tclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [PSC_W-1:0] code,
    output logic             pulse_o
);
    logic [PSC_CNT_W-1:0] cnt_q;
    logic [PSC_CNT_W-1:0] lim;

    assign lim     = psc_limit(code);
    assign pulse_o = adv & (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt_q <= '0;
        else if (pulse_o) cnt_q <= '0;
        else if (adv)     cnt_q <= cnt_q + 1'b1;
    end

    // R8
    div_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && code == '0) |-> pulse_o);

    // R8
    div_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pulse_o || cnt_q == '0);

endmodule

// File: rtl/tclk_src_sel.sv
module tclk_src_sel
    import tclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen,
    input  logic [SEL_W-1:0] slave_mode,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic             ext2_en,
    input  logic             ch_pin,
    input  logic             ch_pol,
    input  logic [FLT_W-1:0] ch_flt,
    input  logic             trg_pin,
    input  logic             trg_pol,
    input  logic [FLT_W-1:0] trg_flt,
    input  logic [PSC_W-1:0] trg_psc,
    output logic             cnt_strobe,
    output logic             trig_flag
);
    src_e               src;
    cond_cfg_t          path_cfg [N_PATHS];
    logic [N_PATHS-1:0] path_pin;
    logic [N_PATHS-1:0] path_edge;
    logic               ch_hit;
    logic               trg_adv;
    logic               trg_pulse;
    logic               sel_pulse;
    logic               strobe_q;
    logic               flag_q;

    assign src = pick_src(ext2_en, slave_mode);

    assign path_pin[PATH_CH]  = ch_pin;
    assign path_pin[PATH_TRG] = trg_pin;
    assign path_cfg[PATH_CH]  = '{pol: ch_pol,  flt: ch_flt};
    assign path_cfg[PATH_TRG] = '{pol: trg_pol, flt: trg_flt};

    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        tclk_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
            .clk    (clk),
            .rst    (rst),
            .pin    (path_pin[p]),
            .cfg    (path_cfg[p]),
            .edge_o (path_edge[p])
        );
    end

    assign ch_hit  = path_edge[PATH_CH] & (trig_sel == TSEL_CH);
    assign trg_adv = path_edge[PATH_TRG] & cen & (src == SRC_TRG);

    tclk_div div_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (src != SRC_TRG),
        .adv     (trg_adv),
        .code    (trg_psc),
        .pulse_o (trg_pulse)
    );

    always_comb begin
        unique case (src)
            SRC_INT: sel_pulse = 1'b1;
            SRC_CH:  sel_pulse = ch_hit;
            SRC_TRG: sel_pulse = trg_pulse;
            default: sel_pulse = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            strobe_q <= cen & sel_pulse;
            flag_q   <= ch_hit & (slave_mode == SMODE_EXT1);
        end
    end

    assign cnt_strobe = strobe_q;
    assign trig_flag  = flag_q;

    // R11
    strobe_needs_cen_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_strobe |-> $past(cen));

    // R2
    internal_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cen && src == SRC_INT) |=> cnt_strobe);

    // R9
    trg_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (ext2_en && !trg_pulse) |=> !cnt_strobe);

    // R10
    flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
        trig_flag |-> ($past(slave_mode) == SMODE_EXT1 && $past(trig_sel) == TSEL_CH));

    // R12
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext2_en && slave_mode != SMODE_INT && slave_mode != SMODE_EXT1) |=> !cnt_strobe);

endmodule

// File: tb/tclk_src_sel_tb_top.sv
module tclk_src_sel_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cen = 1'b0;
    logic [2:0] slave_mode = 3'b000;
    logic [2:0] trig_sel = 3'b110;
    logic       ext2_en = 1'b0;
    logic       ch_pin = 1'b0;
    logic       ch_pol = 1'b0;
    logic [3:0] ch_flt = 4'd0;
    logic       trg_pin = 1'b0;
    logic       trg_pol = 1'b0;
    logic [3:0] trg_flt = 4'd0;
    logic [1:0] trg_psc = 2'd0;
    logic       cnt_strobe;
    logic       trig_flag;

    always #(CLK_P/2) clk = ~clk;

    tclk_src_sel dut_i (
        .clk(clk), .rst(rst), .cen(cen), .slave_mode(slave_mode),
        .trig_sel(trig_sel), .ext2_en(ext2_en),
        .ch_pin(ch_pin), .ch_pol(ch_pol), .ch_flt(ch_flt),
        .trg_pin(trg_pin), .trg_pol(trg_pol), .trg_flt(trg_flt),
        .trg_psc(trg_psc), .cnt_strobe(cnt_strobe), .trig_flag(trig_flag)
    );

    int    vectors = 0;
    int    fails = 0;
    int    n_strobe = 0;
    int    n_flag = 0;
    bit    started = 0;
    bit    done = 0;
    string req = "R1";

    // ---------------- behavioural reference ----------------
    int hist_q [2][$];
    int acc [2];
    int run [2];
    int prv [2];
    int ecount;
    bit exp_s, exp_f;

    always @(posedge clk) begin
        int pin_v [2];
        int pol_v [2];
        int n_v [2];
        bit rise [2];
        int src;
        bit ch, ep;
        pin_v[0] = ch_pin;  pol_v[0] = ch_pol;  n_v[0] = ch_flt;
        pin_v[1] = trg_pin; pol_v[1] = trg_pol; n_v[1] = trg_flt;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin
                hist_q[p].delete();
                acc[p] = 0; run[p] = 0; prv[p] = 0;
            end
            ecount = 0; exp_s = 0; exp_f = 0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                int lv, f;
                lv = (hist_q[p].size() >= 2) ? hist_q[p][hist_q[p].size()-2] : 0;
                lv = lv ^ pol_v[p];
                f  = (n_v[p] == 0) ? lv : acc[p];
                rise[p] = (f == 1) && (prv[p] == 0);
                if (n_v[p] == 0) begin
                    acc[p] = lv; run[p] = 0;
                end else if (lv != acc[p]) begin
                    if (run[p] >= n_v[p] - 1) begin acc[p] = lv; run[p] = 0; end
                    else run[p]++;
                end else run[p] = 0;
                prv[p] = f;
                hist_q[p].push_back(pin_v[p]);
                if (hist_q[p].size() > 3) void'(hist_q[p].pop_front());
            end
            if (ext2_en) src = 3;
            else if (slave_mode == 3'b111) src = 2;
            else if (slave_mode == 3'b000) src = 1;
            else src = 0;
            ch = rise[0] && (trig_sel == 3'b110);
            ep = 0;
            if (src == 3) begin
                if (cen && rise[1]) begin
                    if (ecount >= (1 << trg_psc) - 1) begin ep = 1; ecount = 0; end
                    else ecount++;
                end
            end else ecount = 0;
            exp_s = cen && (src == 1 || (src == 2 && ch) || (src == 3 && ep));
            exp_f = ch && (slave_mode == 3'b111);
        end
    end

    // per-cycle comparison and event counting, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (cnt_strobe !== exp_s || trig_flag !== exp_f) begin
                fails++;
                $display("FAIL %s cycle compare: strobe/flag actual %b/%b expected %b/%b",
                         req, cnt_strobe, trig_flag, exp_s, exp_f);
            end
            if (cnt_strobe === 1'b1) n_strobe++;
            if (trig_flag === 1'b1) n_flag++;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string r, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic ch_pulses(input int cnt, input int hi, input int lo);
        for (int i = 0; i < cnt; i++) begin
            ch_pin = ~ch_pin; tick(hi);
            ch_pin = ~ch_pin; tick(lo);
        end
    endtask

    task automatic trg_pulses(input int cnt, input int hi, input int lo);
        for (int i = 0; i < cnt; i++) begin
            trg_pin = ~trg_pin; tick(hi);
            trg_pin = ~trg_pin; tick(lo);
        end
    endtask

    // cycles from driving the pin until the strobe is observed
    task automatic latency(input bit on_trg, output int k);
        if (on_trg) trg_pin = ~trg_pin; else ch_pin = ~ch_pin;
        k = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            k++;
            if (cnt_strobe === 1'b1) break;
        end
        tick(1);
    endtask

    int s0, f0, lat;

    initial begin
        tick(1);
        started = 1;
        tick(3);
        chk("R1", "strobe in reset", int'(cnt_strobe), 0);
        chk("R1", "flag in reset", int'(trig_flag), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "strobe after reset", int'(cnt_strobe), 0);
        chk("R1", "flag after reset", int'(trig_flag), 0);
        tick(2);

        // R2: timer clock
        req = "R2";
        s0 = n_strobe; cen = 1; tick(10); cen = 0; tick(5);
        chk("R2", "internal strobes for 10 enabled cycles", n_strobe - s0, 10);

        // R3: channel rising edges
        req = "R3";
        slave_mode = 3'b111; trig_sel = 3'b110; tick(4); cen = 1;
        latency(0, lat);
        chk("R3", "pin-to-strobe observation cycle", lat, 4);
        ch_pin = 0; tick(6);
        s0 = n_strobe; f0 = n_flag;
        ch_pulses(5, 3, 4); tick(6);
        chk("R3", "channel strobes", n_strobe - s0, 5);
        chk("R10", "flags with channel strobes", n_flag - f0, 5);

        // R4: falling edges
        req = "R4";
        cen = 0; ch_pin = 1; tick(5); ch_pol = 1; tick(5); cen = 1;
        s0 = n_strobe;
        ch_pulses(5, 3, 4); tick(6);
        chk("R4", "falling-edge strobes", n_strobe - s0, 5);
        cen = 0; ch_pol = 0; tick(6); ch_pin = 0; tick(6);

        // R5: filter
        req = "R5";
        ch_flt = 4'd3; tick(4); cen = 1;
        s0 = n_strobe;
        ch_pulses(3, 2, 6); tick(8);
        chk("R5", "short pulses rejected", n_strobe - s0, 0);
        s0 = n_strobe;
        ch_pulses(2, 6, 6); tick(8);
        chk("R5", "long pulses accepted", n_strobe - s0, 2);
        latency(0, lat);
        chk("R5", "filtered observation cycle", lat, 7);
        ch_pin = 0; tick(8); ch_flt = 4'd0; tick(4);

        // R6: other input select
        req = "R6";
        trig_sel = 3'b101; s0 = n_strobe; f0 = n_flag;
        ch_pulses(4, 3, 3); tick(6);
        chk("R6", "strobes with unselected input", n_strobe - s0, 0);
        chk("R6", "flags with unselected input", n_flag - f0, 0);
        trig_sel = 3'b110;

        // R7: trigger path
        req = "R7";
        slave_mode = 3'b000; ext2_en = 1; trg_psc = 0; tick(4);
        latency(1, lat);
        chk("R7", "trigger observation cycle", lat, 4);
        trg_pin = 0; tick(6);
        trg_flt = 4'd2; tick(4);
        latency(1, lat);
        chk("R7", "filtered trigger observation cycle", lat, 6);
        trg_pin = 0; tick(8);
        cen = 0; trg_pin = 1; tick(6); trg_pol = 1; tick(6); cen = 1;
        s0 = n_strobe;
        trg_pulses(4, 4, 4); tick(8);
        chk("R7", "falling trigger strobes", n_strobe - s0, 4);
        cen = 0; trg_pol = 0; tick(6); trg_pin = 0; trg_flt = 0; tick(6); cen = 1;

        // R8: prescaler
        req = "R8";
        for (int c = 0; c < 4; c++) begin
            ext2_en = 0; slave_mode = 3'b011; tick(2);
            ext2_en = 1; trg_psc = 2'(c); tick(2);
            s0 = n_strobe;
            trg_pulses(16, 3, 3); tick(8);
            chk("R8", $sformatf("strobes for 16 edges code %0d", c), n_strobe - s0, 16 >> c);
        end
        trg_psc = 0;

        // R9: trigger path overrides both other sources
        req = "R9";
        slave_mode = 3'b111; tick(4);
        s0 = n_strobe; f0 = n_flag;
        ch_pulses(4, 3, 3); tick(6);
        chk("R9", "no strobes while trigger path idle", n_strobe - s0, 0);
        chk("R10", "flags while trigger path enabled", n_flag - f0, 4);
        slave_mode = 3'b000; s0 = n_strobe; tick(8);
        chk("R9", "timer clock overridden", n_strobe - s0, 0);

        // R10 / R11: count enable low
        req = "R11";
        ext2_en = 0; slave_mode = 3'b111; cen = 0; tick(4);
        s0 = n_strobe; f0 = n_flag;
        ch_pulses(3, 3, 3); tick(6);
        chk("R11", "no strobes with cen low", n_strobe - s0, 0);
        chk("R10", "flags with cen low", n_flag - f0, 3);

        // R12: unused slave modes
        req = "R12";
        slave_mode = 3'b011; cen = 1; s0 = n_strobe; tick(10);
        chk("R12", "no strobes in unused mode", n_strobe - s0, 0);

        // random phase, all requirements through the model
        req = "R3-random";
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 0) begin
                slave_mode = ($urandom_range(0, 2) == 0) ? 3'($urandom) :
                             (($urandom_range(0, 1) == 0) ? 3'b000 : 3'b111);
                trig_sel = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b110;
                ext2_en = 1'($urandom);
                cen = ($urandom_range(0, 4) != 0);
                ch_pol = 1'($urandom); trg_pol = 1'($urandom);
                ch_flt = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(1, 5));
                trg_flt = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(1, 5));
                trg_psc = 2'($urandom);
            end
            if (i == 1500) rst = 1;
            if (i == 1503) rst = 0;
            if ($urandom_range(0, 3) == 0) ch_pin = ~ch_pin;
            if ($urandom_range(0, 3) == 0) trg_pin = ~trg_pin;
            tick(1);
        end
        tick(4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule